// File: doc/BRIEF.md
# Floating-Point to Integer Conversion Unit

This block turns an IEEE-754 binary value into an integer. The source may be single precision, carried in the low 32 bits of the operand word, or double precision, carried in all 64 bits. The destination is a 32-bit or 64-bit integer and may be signed or unsigned. Every conversion truncates toward zero. A 5-bit mode input selects what happens when a value does not fit. In clamping mode the result is pinned to the destination limits. In wrapping mode the exact integer is reduced modulo 2^N, which follows the script-language 32-bit conversion rule and extends it to the other widths.

Alongside the integer, the unit keeps an overflow flag and a sticky summary-overflow flag. It can also write a 4-bit condition field describing the result. All outputs are registered and appear one cycle after a request. The surrounding pipeline issues requests with `valid_i` and clears the sticky flag with `so_clr_i`.

Top module: `fp2int_unit`

## Requirements
- R1: In clamping mode, NaN gives 0, +Inf gives the destination maximum, and -Inf gives the destination minimum (0 when unsigned).
- R2: A finite value whose truncated integer fits the destination is returned exactly, with the fraction discarded toward zero. -0.0 gives 0.
- R3: In clamping mode, an out-of-range finite value gives the destination maximum when positive and the minimum when negative. The minimum is 0 for unsigned destinations.
- R4: In wrapping mode, NaN and both infinities give 0. A finite value gives the low N bits of the two's-complement truncated integer, for any exponent.
- R5: A 32-bit destination result is sign-extended to 64 bits when signed and zero-extended when unsigned.
- R6: When `src_dp_i`=0, the operand is single precision in bits 31:0, with the sign at bit 31, the exponent at bits 30:23 and the fraction at bits 22:0. When `src_dp_i`=1, the operand is double precision, with the sign at bit 63, the exponent at bits 62:52 and the fraction at bits 51:0.
- R7: When a request has `oe_i`=1, `ov_o` becomes 1 exactly when the result does not equal the input value. This covers a lost fraction, clamping, wrapping, NaN and infinity.
- R8: A request with `oe_i`=0 leaves both `ov_o` and `so_o` unchanged.
- R9: `so_o` is set by any overflow that `oe_i` enables and stays set until `so_clr_i`. When a clear and a new overflow arrive in the same cycle, the flag ends up set.
- R10: A request with `rc_i`=1 writes `cr_o` as {negative, positive, zero, SO}. The sign is taken from the 64-bit result read as signed, and the SO bit is the updated `so_o`. A request with `rc_i`=0 leaves `cr_o` unchanged.
- R11: `mode_i`=1 selects wrapping. Every other mode value selects clamping.
- R12: Outputs change one cycle after `valid_i`, and `valid_o` marks that cycle. Without `valid_i`, `result_o` holds its value.
- R13: Reset clears `result_o`, `ov_o`, `so_o`, `cr_o` and `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Conversion request |
| src_dp_i | input | 1 | 1 = double-precision source, 0 = single |
| dst_dw_i | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| dst_signed_i | input | 1 | 1 = signed destination |
| mode_i | input | 5 | Overflow behaviour: 1 wraps, others clamp |
| oe_i | input | 1 | Enable the overflow flag update |
| rc_i | input | 1 | Enable the condition field update |
| so_clr_i | input | 1 | Clear the sticky summary flag |
| operand_i | input | 64 | Floating-point operand |
| result_o | output | 64 | Integer result |
| ov_o | output | 1 | Overflow flag |
| so_o | output | 1 | Sticky summary-overflow flag |
| cr_o | output | 4 | Condition field {lt, gt, eq, so} |
| valid_o | output | 1 | Result valid |

## Verification
The bench goes after the edges of each range:

- **Exact signed minimum.** -2^31 must convert with no overflow. A range check that is off by one would raise a false overflow or clamp the value.
- **Largest values.** 2^31 into an unsigned 32-bit destination and 2^63 into an unsigned 64-bit destination must convert exactly, while the same values into signed destinations must clamp.
- **Wrapping beyond the integer width.** Exponents above 64 and at 200 must still return the right low bits. A design that clamps or keeps the wrong bits would return a wrong residue.
- **Negative values into unsigned destinations.** -0.75 must give 0 with overflow set, and -1.0 must wrap to all ones in the low 32 bits. A wrong extension step would show up as stray upper bits.
- **Special encodings.** Subnormals, -0.0, NaN and infinities are checked in both modes. A mode value other than 0 or 1 must fall back to clamping.
- **Flag behaviour.** The bench checks that the flags stay put when their enables are low, and that a clear arriving with a new overflow leaves the sticky flag set.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int WORD_W    = 64;
    localparam int HALF_W    = 32;
    localparam int SIG_W     = DP_FRAC_W + 1;
    localparam int EXP_W     = DP_EXP_W + 2;
    localparam int CR_W      = 4;
    localparam int MODE_W    = 5;
    localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
    localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
    localparam logic [MODE_W-1:0] MODE_WRAP = MODE_W'(1);

    // unified view of either precision: value = sig * 2^(exp - (SIG_W-1))
    typedef struct packed {
        logic                    sign;
        logic signed [EXP_W-1:0] exp;
        logic [SIG_W-1:0]        sig;
        logic                    nan;
        logic                    inf;
    } fp_unpacked_t;

    typedef struct packed {
        logic [WORD_W-1:0] mag;        // low bits of the truncated magnitude
        logic              huge;       // magnitude >= 2^WORD_W
        logic              frac_lost;  // nonzero fraction discarded
    } int_mag_t;

    typedef struct packed {
        logic [WORD_W-1:0] result;
        logic              ov;
        logic              so;
        logic [CR_W-1:0]   cr;
        logic              vld;
    } cvt_state_t;
endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
    import fp2int_pkg::*;
(
    input  logic              dp_i,
    input  logic [WORD_W-1:0] op_i,
    output fp_unpacked_t      up_o
);
    logic [DP_EXP_W-1:0]  d_exp;
    logic [DP_FRAC_W-1:0] d_frac;
    logic [SP_EXP_W-1:0]  s_exp;
    logic [SP_FRAC_W-1:0] s_frac;
    logic                 exp_max;
    logic                 exp_min;
    logic                 frac_nz;

    assign d_exp  = op_i[WORD_W-2 -: DP_EXP_W];
    assign d_frac = op_i[DP_FRAC_W-1:0];
    assign s_exp  = op_i[HALF_W-2 -: SP_EXP_W];
    assign s_frac = op_i[SP_FRAC_W-1:0];

    always_comb begin
        up_o = '0;
        if (dp_i) begin
            exp_max   = &d_exp;
            exp_min   = ~|d_exp;
            frac_nz   = |d_frac;
            up_o.sign = op_i[WORD_W-1];
            up_o.sig  = {~exp_min, d_frac};
            up_o.exp  = exp_min ? EXP_W'(1 - DP_BIAS)
                                : EXP_W'(int'(d_exp) - DP_BIAS);
        end else begin
            exp_max   = &s_exp;
            exp_min   = ~|s_exp;
            frac_nz   = |s_frac;
            up_o.sign = op_i[HALF_W-1];
            up_o.sig  = {~exp_min, s_frac, {(SIG_W-1-SP_FRAC_W){1'b0}}};
            up_o.exp  = exp_min ? EXP_W'(1 - SP_BIAS)
                                : EXP_W'(int'(s_exp) - SP_BIAS);
        end
        up_o.nan = exp_max & frac_nz;
        up_o.inf = exp_max & ~frac_nz;
    end
endmodule

// File: rtl/fp2int_magnitude.sv
module fp2int_magnitude
    import fp2int_pkg::*;
(
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0]        sig_i,
    output int_mag_t                mag_o
);
    localparam int POINT = SIG_W - 1;

    int rsh;
    int lsh;

    always_comb begin
        mag_o = '0;
        rsh   = 0;
        lsh   = 0;
        if (exp_i < 0) begin
            mag_o.frac_lost = |sig_i;
        end else if (int'(exp_i) <= POINT) begin
            rsh             = POINT - int'(exp_i);
            mag_o.mag       = WORD_W'(sig_i >> rsh);
            mag_o.frac_lost = |(sig_i & ~({SIG_W{1'b1}} << rsh));
        end else begin
            lsh        = int'(exp_i) - POINT;
            mag_o.huge = int'(exp_i) >= WORD_W;
            if (lsh < WORD_W) begin
                mag_o.mag = {{(WORD_W-SIG_W){1'b0}}, sig_i} << lsh;
            end
        end
    end
endmodule

// File: rtl/fp2int_select.sv
module fp2int_select
    import fp2int_pkg::*;
(
    input  logic              sign_i,
    input  logic              nan_i,
    input  logic              inf_i,
    input  int_mag_t          mag_i,
    input  logic              dw_i,
    input  logic              sg_i,
    input  logic              wrap_i,
    output logic [WORD_W-1:0] value_o,
    output logic              inexact_o
);
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    int                n;
    logic [WORD_W-1:0] pos_lim;
    logic [WORD_W-1:0] neg_lim;
    logic [WORD_W-1:0] exact;
    logic [WORD_W-1:0] raw;
    logic              in_range;

    always_comb begin
        n = dw_i ? WORD_W : HALF_W;
        if (sg_i) begin
            pos_lim = (ONE << (n - 1)) - ONE;
            neg_lim = ONE << (n - 1);
        end else begin
            pos_lim = dw_i ? {WORD_W{1'b1}} : (ONE << n) - ONE;
            neg_lim = '0;
        end
        in_range = ~mag_i.huge & (sign_i ? (mag_i.mag <= neg_lim)
                                         : (mag_i.mag <= pos_lim));
        exact    = sign_i ? (~mag_i.mag + ONE) : mag_i.mag;

        if (wrap_i) begin
            raw = (nan_i | inf_i) ? '0 : exact;
        end else if (nan_i) begin
            raw = '0;
        end else if (inf_i | ~in_range) begin
            raw = sign_i ? (~neg_lim + ONE) : pos_lim;
        end else begin
            raw = exact;
        end

        if (dw_i) begin
            value_o = raw;
        end else if (sg_i) begin
            value_o = {{(WORD_W-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
        end else begin
            value_o = {{(WORD_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
        end

        inexact_o = nan_i | inf_i | mag_i.frac_lost | ~in_range;
    end
endmodule

// File: rtl/fp2int_unit.sv
module fp2int_unit
    import fp2int_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              src_dp_i,
    input  logic              dst_dw_i,
    input  logic              dst_signed_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              oe_i,
    input  logic              rc_i,
    input  logic              so_clr_i,
    input  logic [WORD_W-1:0] operand_i,
    output logic [WORD_W-1:0] result_o,
    output logic              ov_o,
    output logic              so_o,
    output logic [CR_W-1:0]   cr_o,
    output logic              valid_o
);
    fp_unpacked_t      up;
    int_mag_t          mag;
    logic [WORD_W-1:0] value;
    logic              inexact;
    logic              wrap;
    logic              ov_hit;
    cvt_state_t        st_d;
    cvt_state_t        st_q;

    assign wrap = (mode_i == MODE_WRAP);

    fp2int_unpack u_unpack (
        .dp_i (src_dp_i),
        .op_i (operand_i),
        .up_o (up)
    );

    fp2int_magnitude u_mag (
        .exp_i (up.exp),
        .sig_i (up.sig),
        .mag_o (mag)
    );

    fp2int_select u_sel (
        .sign_i    (up.sign),
        .nan_i     (up.nan),
        .inf_i     (up.inf),
        .mag_i     (mag),
        .dw_i      (dst_dw_i),
        .sg_i      (dst_signed_i),
        .wrap_i    (wrap),
        .value_o   (value),
        .inexact_o (inexact)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        ov_hit   = valid_i & oe_i & inexact;
        st_d.so  = (so_clr_i ? 1'b0 : st_q.so) | ov_hit;
        if (valid_i) begin
            st_d.result = value;
            if (oe_i) begin
                st_d.ov = inexact;
            end
            if (rc_i) begin
                st_d.cr = {value[WORD_W-1], ~value[WORD_W-1] & (|value),
                           ~|value, st_d.so};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign ov_o     = st_q.ov;
    assign so_o     = st_q.so;
    assign cr_o     = st_q.cr;
    assign valid_o  = st_q.vld;
endmodule

// File: rtl/fp2int_unit_chk.sv
module fp2int_unit_chk
    import fp2int_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              src_dp_i,
    input logic              oe_i,
    input logic              rc_i,
    input logic              so_clr_i,
    input logic [WORD_W-2:0] fp_bits_i,
    input logic [WORD_W-1:0] result_o,
    input logic              ov_o,
    input logic              so_o,
    input logic [CR_W-1:0]   cr_o,
    input logic              valid_o
);
    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R12
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && $stable(result_o)));

    // R9
    so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_o && !so_clr_i) |=> so_o);

    // R9
    ov_sets_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_o) |-> so_o);

    // R8
    ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && oe_i) |=> $stable(ov_o));

    // R10
    cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && rc_i) |=> $stable(cr_o));

    // R10
    cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && rc_i) |=> ($countones(cr_o[CR_W-1:1]) == 1));

    // R1
    nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && src_dp_i && (&fp_bits_i[WORD_W-2:WORD_W-1-DP_EXP_W])
         && (|fp_bits_i[DP_FRAC_W-1:0])) |=> (result_o == '0));
endmodule

bind fp2int_unit fp2int_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .src_dp_i  (src_dp_i),
    .oe_i      (oe_i),
    .rc_i      (rc_i),
    .so_clr_i  (so_clr_i),
    .fp_bits_i (operand_i[62:0]),
    .result_o  (result_o),
    .ov_o      (ov_o),
    .so_o      (so_o),
    .cr_o      (cr_o),
    .valid_o   (valid_o)
);

// File: tb/fp2int_unit_tb_top.sv
`timescale 1ns/1ps
module fp2int_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        src_dp_i = 1'b0;
    logic        dst_dw_i = 1'b0;
    logic        dst_signed_i = 1'b0;
    logic [4:0]  mode_i = '0;
    logic        oe_i = 1'b0;
    logic        rc_i = 1'b0;
    logic        so_clr_i = 1'b0;
    logic [63:0] operand_i = '0;
    logic [63:0] result_o;
    logic        ov_o;
    logic        so_o;
    logic [3:0]  cr_o;
    logic        valid_o;

    int errors = 0;
    int checks = 0;
    logic so_m = 1'b0;

    always #4 clk = ~clk;

    fp2int_unit dut_i (.*);

    typedef struct packed {
        logic        dp;
        logic        dw;
        logic        sg;
        logic [4:0]  mode;
        logic [63:0] op;
        logic [63:0] res;
        logic        ov;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b1,5'd0,64'h3FF0000000000000,64'h0000000000000001,1'b0}, // R2 1.0
        '{1'b1,1'b0,1'b1,5'd0,64'hC004000000000000,64'hFFFFFFFFFFFFFFFE,1'b1}, // R2 -2.5
        '{1'b1,1'b0,1'b1,5'd0,64'h41F0000000000000,64'h000000007FFFFFFF,1'b1}, // R3 2^32
        '{1'b1,1'b0,1'b1,5'd1,64'h41F0000000000000,64'h0000000000000000,1'b1}, // R4
        '{1'b1,1'b0,1'b0,5'd0,64'h41F0000000000000,64'h00000000FFFFFFFF,1'b1}, // R3 R5
        '{1'b1,1'b0,1'b1,5'd1,64'h41E0000000000000,64'hFFFFFFFF80000000,1'b1}, // R4 R5
        '{1'b1,1'b0,1'b0,5'd0,64'h41E0000000000000,64'h0000000080000000,1'b0}, // R5 2^31
        '{1'b1,1'b0,1'b1,5'd0,64'hC1E0000000000000,64'hFFFFFFFF80000000,1'b0}, // R3 -2^31
        '{1'b1,1'b0,1'b1,5'd0,64'h7FF8000000000000,64'h0000000000000000,1'b1}, // R1 NaN
        '{1'b1,1'b1,1'b1,5'd1,64'h7FF8000000000000,64'h0000000000000000,1'b1}, // R4 NaN
        '{1'b1,1'b1,1'b1,5'd0,64'h7FF0000000000000,64'h7FFFFFFFFFFFFFFF,1'b1}, // R1 +Inf
        '{1'b1,1'b1,1'b0,5'd1,64'h7FF0000000000000,64'h0000000000000000,1'b1}, // R4 +Inf
        '{1'b1,1'b1,1'b1,5'd0,64'hFFF0000000000000,64'h8000000000000000,1'b1}, // R1 -Inf
        '{1'b1,1'b0,1'b0,5'd0,64'hFFF0000000000000,64'h0000000000000000,1'b1}, // R1 -Inf u
        '{1'b1,1'b0,1'b0,5'd1,64'hBFF0000000000000,64'h00000000FFFFFFFF,1'b1}, // R4 R5 -1
        '{1'b1,1'b1,1'b0,5'd0,64'hBFF0000000000000,64'h0000000000000000,1'b1}, // R3 -1 u64
        '{1'b1,1'b1,1'b1,5'd1,64'hBFF0000000000000,64'hFFFFFFFFFFFFFFFF,1'b0}, // R4 -1 s64
        '{1'b0,1'b0,1'b1,5'd0,64'h000000003FC00000,64'h0000000000000001,1'b1}, // R6 1.5f
        '{1'b0,1'b0,1'b0,5'd0,64'h00000000BF400000,64'h0000000000000000,1'b1}, // R6 -0.75f
        '{1'b0,1'b1,1'b0,5'd0,64'h000000005F000000,64'h8000000000000000,1'b0}, // R6 2^63f
        '{1'b0,1'b1,1'b1,5'd0,64'h000000005F000000,64'h7FFFFFFFFFFFFFFF,1'b1}, // R3 R6
        '{1'b0,1'b1,1'b1,5'd1,64'h000000005F000000,64'h8000000000000000,1'b1}, // R4 R6
        '{1'b1,1'b1,1'b1,5'd1,64'h43F0000000000002,64'h0000000000002000,1'b1}, // R4 2^64+2^13
        '{1'b1,1'b1,1'b1,5'd0,64'h43F0000000000002,64'h7FFFFFFFFFFFFFFF,1'b1}, // R3
        '{1'b1,1'b0,1'b1,5'd1,64'h4C70000000000000,64'h0000000000000000,1'b1}, // R4 2^200
        '{1'b1,1'b1,1'b1,5'd0,64'h0000000000000001,64'h0000000000000000,1'b1}, // R2 subnormal
        '{1'b1,1'b0,1'b1,5'd0,64'h8000000000000000,64'h0000000000000000,1'b0}, // R2 -0.0
        '{1'b1,1'b0,1'b1,5'd7,64'h41F0000000000000,64'h000000007FFFFFFF,1'b1}, // R11 mode 7
        '{1'b1,1'b0,1'b1,5'd1,64'h41F0000000100000,64'h0000000000000001,1'b1}, // R4 2^32+1
        '{1'b1,1'b0,1'b1,5'd1,64'hC1E0000000200000,64'h000000007FFFFFFF,1'b1}  // R4 -(2^31+1)
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic conv(input logic dp, input logic dw, input logic sg, input logic [4:0] md,
                        input logic oe, input logic rc, input logic clr, input logic [63:0] op);
        @(negedge clk);
        valid_i = 1'b1; src_dp_i = dp; dst_dw_i = dw; dst_signed_i = sg;
        mode_i = md; oe_i = oe; rc_i = rc; so_clr_i = clr; operand_i = op;
        @(negedge clk);
        valid_i = 1'b0; so_clr_i = 1'b0;
    endtask

    function automatic logic [3:0] cr_of(input logic [63:0] r, input logic so);
        return {r[63], ~r[63] & (|r), ~|r, so};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 result", result_o, 64'h0);
        chk("R13 flags", {63'h0, ov_o | so_o | valid_o}, 64'h0);
        chk("R13 cr", {60'h0, cr_o}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            conv(VECS[i].dp, VECS[i].dw, VECS[i].sg, VECS[i].mode, 1'b1, 1'b1, 1'b0, VECS[i].op);
            so_m = so_m | VECS[i].ov;
            chk($sformatf("row %0d result R2 R3 R4", i), result_o, VECS[i].res);
            chk($sformatf("row %0d R7 ov", i), {63'h0, ov_o}, {63'h0, VECS[i].ov});
            chk($sformatf("row %0d R10 cr", i), {60'h0, cr_o}, {60'h0, cr_of(VECS[i].res, so_m)});
            chk($sformatf("row %0d R12 valid", i), {63'h0, valid_o}, 64'h1);
        end
        chk("R9 sticky after table", {63'h0, so_o}, 64'h1);

        // R12 idle cycle keeps result, drops valid
        @(negedge clk);
        chk("R12 idle valid", {63'h0, valid_o}, 64'h0);
        chk("R12 idle hold", result_o, VECS[NV-1].res);

        // R9 explicit clear
        @(negedge clk); so_clr_i = 1'b1;
        @(negedge clk); so_clr_i = 1'b0;
        chk("R9 clear", {63'h0, so_o}, 64'h0);

        // exact conversion rewrites ov to 0, cr positive with so 0
        conv(1'b1, 1'b0, 1'b1, 5'd0, 1'b1, 1'b1, 1'b0, 64'h3FF0000000000000);
        chk("R7 exact ov", {63'h0, ov_o}, 64'h0);
        chk("R10 cr gt", {60'h0, cr_o}, 64'h4);

        // R8 NaN with oe=0 leaves ov and so alone
        conv(1'b1, 1'b0, 1'b1, 5'd0, 1'b0, 1'b1, 1'b0, 64'h7FF8000000000000);
        chk("R8 ov held", {63'h0, ov_o}, 64'h0);
        chk("R8 so held", {63'h0, so_o}, 64'h0);
        chk("R10 cr eq", {60'h0, cr_o}, 64'h2);

        // R10 rc=0 keeps cr while result updates
        conv(1'b1, 1'b0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 64'hBFF0000000000000);
        chk("R10 result", result_o, 64'hFFFFFFFFFFFFFFFF);
        chk("R10 cr held", {60'h0, cr_o}, 64'h2);

        // R9 clear and set in the same cycle leaves so set
        conv(1'b1, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 64'h7FF8000000000000);
        chk("R9 clear+set so", {63'h0, so_o}, 64'h1);
        chk("R7 NaN ov", {63'h0, ov_o}, 64'h1);
        chk("R10 cr so bit", {60'h0, cr_o}, 64'h3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule